// File: doc/BRIEF.md
# Multiplexed Bus Write Front End

This block is the write-side slave front end for a 32-bit multiplexed address/data bus in which one set of lines carries the register address during an address phase and the write data during a data phase. An address strobe marks the address phase. Chip select, write strobe and four active-low lane enables qualify the data phase. All bus strobes are asynchronous to the block and are brought into a faster internal clock by synchronizer chains. Edges are then detected on the synchronized levels.

The block captures the low eight bits of the address when the address strobe falls and ignores the upper lines. When the combined write strobe (write low and select low) is released, it commits the write. A write whose latched address lies inside a parameterized window goes to a FIFO port, which accepts one byte, an aligned 16-bit half or a full 32-bit word. Any other address goes to an 8-bit register port, which takes exactly one byte. A write with a lane pattern that the target cannot take is dropped and raises a one-cycle error pulse. A data phase without a preceding address phase reuses the last latched address, so repeated writes to one location need no address cycle.

Top module: `mbw_slave`

## Requirements
- R1: After reset, fifo_we_o, reg_we_o and err_o stay low until a write strobe is released.
- R2: At a falling edge of ale_i, the target address is taken from ad_i[7:0], and ad_i[31:8] have no effect on it.
- R3: A data phase with no preceding ale_i pulse uses the address latched most recently.
- R4: A write commits once per release of the combined strobe, which is active while wr_ni and cs_ni are both low. Each commit is a single one-cycle pulse on exactly one of fifo_we_o, reg_we_o or err_o. A wr_ni pulse while cs_ni stays high commits nothing.
- R5: The output pulse appears on the third rising clock edge after the strobe release is applied at the pins (SYNC_STAGES = 2).
- R6: Addresses from FIFO_LO to FIFO_HI (default 0x40 to 0x43) route to the FIFO port. All other addresses route to the register port.
- R7: A FIFO write is accepted for the enabled-lane sets (enable = ~be_ni, bit i covering ad_i[8i+7:8i]) {0}, {1}, {2}, {3}, {0,1}, {2,3} and {0,1,2,3}. On acceptance, fifo_mask_o equals the enabled set and fifo_data_o carries ad_i on the enabled lanes and zero elsewhere.
- R8: A FIFO write with any other enable set, including none, gives an err_o pulse and no fifo_we_o.
- R9: A register write with exactly one enabled lane gives a reg_we_o pulse. reg_data_o holds that lane's byte and reg_addr_o holds the latched address.
- R10: A register write with zero or several enabled lanes gives an err_o pulse and no reg_we_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock, faster than the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ad_i | input | 32 | Multiplexed address/data lines |
| be_ni | input | 4 | Active-low byte-lane enables |
| ale_i | input | 1 | Address latch enable, active high |
| wr_ni | input | 1 | Write strobe, active low |
| cs_ni | input | 1 | Chip select, active low |
| fifo_we_o | output | 1 | FIFO write pulse |
| fifo_mask_o | output | 4 | FIFO lane mask, bit i for byte i |
| fifo_data_o | output | 32 | FIFO write data, disabled lanes zero |
| reg_we_o | output | 1 | Register write pulse |
| reg_addr_o | output | 8 | Register address |
| reg_data_o | output | 8 | Register write data |
| err_o | output | 1 | Rejected write pulse |

## Verification
If the latched address is wrong, the next commit shows it at once, either as a wrong reg_addr_o or as a write routed to the other port. If the synchronizer or edge state is wrong, a commit shifts from the expected third edge, a pulse repeats, or a pulse goes missing entirely. These faults show within one transaction. The bench sweeps all sixteen lane patterns against both targets and reads mask, data, error and latency at the ports on every write.

// File: rtl/mbw_pkg.sv
package mbw_pkg;
  localparam int LANES  = 4;
  localparam int DATA_W = LANES * 8;

  typedef logic [LANES-1:0] lane_t;

  // naturally aligned power-of-two lane group
  function automatic logic fifo_lanes_ok(lane_t en);
    logic ok;
    ok = 1'b0;
    for (int w = 1; w <= LANES; w = w * 2) begin
      for (int s = 0; s + w <= LANES; s = s + w) begin
        if (en == lane_t'(((1 << w) - 1) << s)) ok = 1'b1;
      end
    end
    return ok;
  endfunction

  function automatic logic [1:0] lane_index(lane_t en);
    logic [1:0] idx;
    idx = '0;
    for (int i = 0; i < LANES; i++) begin
      if (en[i]) idx = 2'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/mbw_sync.sv
module mbw_sync #(
  parameter int          WIDTH  = 1,
  parameter int          STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else         chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/mbw_addr_latch.sv
module mbw_addr_latch #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        addr_o <= '0;
    else if (capture_i) addr_o <= addr_i;
  end

  // address survives until the next address phase
  assert_addr_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(addr_o));
endmodule

// File: rtl/mbw_lane_decode.sv
module mbw_lane_decode
  import mbw_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  lane_t             be_ni,
  input  logic              is_fifo_i,
  output logic              fifo_ok_o,
  output logic              reg_ok_o,
  output lane_t             mask_o,
  output logic [DATA_W-1:0] fifo_data_o,
  output logic [7:0]        reg_byte_o
);
  lane_t en;
  logic [LANES-1:0][7:0] lane_bytes;

  assign en     = ~be_ni;
  assign mask_o = en;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_bytes[l]            = data_i[8*l +: 8];
    assign fifo_data_o[8*l +: 8]    = en[l] ? data_i[8*l +: 8] : 8'h00;
  end

  assign reg_byte_o = lane_bytes[lane_index(en)];
  assign fifo_ok_o  = is_fifo_i && fifo_lanes_ok(en);
  assign reg_ok_o   = !is_fifo_i && ($countones(en) == 1);
endmodule

// File: rtl/mbw_slave.sv
module mbw_slave
  import mbw_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter logic [7:0] FIFO_LO     = 8'h40,
  parameter logic [7:0] FIFO_HI     = 8'h43,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       ad_i,
  input  logic [3:0]        be_ni,
  input  logic              ale_i,
  input  logic              wr_ni,
  input  logic              cs_ni,
  output logic              fifo_we_o,
  output logic [3:0]        fifo_mask_o,
  output logic [31:0]       fifo_data_o,
  output logic              reg_we_o,
  output logic [7:0]        reg_addr_o,
  output logic [7:0]        reg_data_o,
  output logic              err_o
);
  localparam logic [2:0] SYNC_RST = 3'b110; // {cs, wr, ale}: strobes idle

  logic [2:0] sync_lvl;
  logic       ale_s, wr_s, cs_s;
  logic       ale_d, strobe_d;
  logic       strobe_s, ale_fall, wr_done;
  logic [ADDR_W-1:0] addr_q;
  logic       is_fifo, fifo_ok, reg_ok;
  lane_t      dec_mask;
  logic [DATA_W-1:0] dec_data;
  logic [7:0] dec_byte;

  mbw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({cs_ni, wr_ni, ale_i}),
    .sync_o  (sync_lvl)
  );
  assign {cs_s, wr_s, ale_s} = sync_lvl;

  // high = idle; released when either line returns high
  assign strobe_s = wr_s | cs_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ale_d    <= 1'b0;
      strobe_d <= 1'b1;
    end else begin
      ale_d    <= ale_s;
      strobe_d <= strobe_s;
    end
  end

  assign ale_fall = ale_d & ~ale_s;
  assign wr_done  = strobe_s & ~strobe_d;

  mbw_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (ale_fall),
    .addr_i    (ad_i[ADDR_W-1:0]),
    .addr_o    (addr_q)
  );

  assign is_fifo = (addr_q >= FIFO_LO) && (addr_q <= FIFO_HI);

  mbw_lane_decode u_dec (
    .data_i      (ad_i),
    .be_ni       (be_ni),
    .is_fifo_i   (is_fifo),
    .fifo_ok_o   (fifo_ok),
    .reg_ok_o    (reg_ok),
    .mask_o      (dec_mask),
    .fifo_data_o (dec_data),
    .reg_byte_o  (dec_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fifo_we_o   <= 1'b0;
      fifo_mask_o <= '0;
      fifo_data_o <= '0;
      reg_we_o    <= 1'b0;
      reg_addr_o  <= '0;
      reg_data_o  <= '0;
      err_o       <= 1'b0;
    end else begin
      fifo_we_o <= wr_done & fifo_ok;
      reg_we_o  <= wr_done & reg_ok;
      err_o     <= wr_done & ~fifo_ok & ~reg_ok;
      if (wr_done & fifo_ok) begin
        fifo_mask_o <= dec_mask;
        fifo_data_o <= dec_data;
      end
      if (wr_done & reg_ok) begin
        reg_addr_o <= addr_q;
        reg_data_o <= dec_byte;
      end
    end
  end

  assert_one_target_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fifo_we_o, reg_we_o, err_o}));

  assert_single_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_we_o || reg_we_o || err_o) |=> !(fifo_we_o || reg_we_o || err_o));

  assert_commit_on_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_we_o || reg_we_o || err_o) |-> $past(wr_done));

  assert_reg_outside_window_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> !((reg_addr_o >= FIFO_LO) && (reg_addr_o <= FIFO_HI)));

  assert_fifo_mask_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_we_o |-> fifo_lanes_ok(fifo_mask_o));

  assert_reg_single_lane_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> $past($countones(~be_ni) == 1));
endmodule

// File: tb/mbw_slave_bench.sv
module mbw_slave_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0]  be_n = 4'hF;
  logic        ale = 1'b0, wr_n = 1'b1, cs_n = 1'b1;
  logic        fifo_we, reg_we, err;
  logic [3:0]  fifo_mask;
  logic [31:0] fifo_data;
  logic [7:0]  reg_addr, reg_data;

  int checks = 0, failures = 0;
  int cyc = 0;
  int n_fifo = 0, n_reg = 0, n_err = 0, last_ev_cyc = 0;
  logic [3:0]  s_mask;
  logic [31:0] s_fdata;
  logic [7:0]  s_addr, s_rdata;
  bit          done = 0;

  always #5 clk = ~clk;

  mbw_slave u_mbw_slave (
    .clk_i(clk), .rst_ni(rst_n), .ad_i(ad), .be_ni(be_n), .ale_i(ale),
    .wr_ni(wr_n), .cs_ni(cs_n), .fifo_we_o(fifo_we), .fifo_mask_o(fifo_mask),
    .fifo_data_o(fifo_data), .reg_we_o(reg_we), .reg_addr_o(reg_addr),
    .reg_data_o(reg_data), .err_o(err)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (fifo_we) begin n_fifo++; s_mask = fifo_mask; s_fdata = fifo_data; last_ev_cyc = cyc; end
    if (reg_we)  begin n_reg++;  s_addr = reg_addr;  s_rdata = reg_data;  last_ev_cyc = cyc; end
    if (err)     begin n_err++;  last_ev_cyc = cyc; end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic addr_phase(logic [7:0] a, logic [23:0] junk);
    @(negedge clk); ad = {junk, a}; ale = 1'b1;
    repeat (4) @(negedge clk);
    ale = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  // returns counts delta and latency via outputs
  task automatic data_phase(logic [31:0] d, logic [3:0] ben, logic sel,
                            output int df, output int dr, output int de, output int lat);
    int f0, r0, e0, rel;
    @(negedge clk); ad = d; be_n = ben; cs_n = ~sel; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    f0 = n_fifo; r0 = n_reg; e0 = n_err; rel = cyc;
    wr_n = 1'b1; cs_n = 1'b1;
    repeat (8) @(negedge clk);
    df = n_fifo - f0; dr = n_reg - r0; de = n_err - e0; lat = last_ev_cyc - rel;
    be_n = 4'hF;
  endtask

  function automatic bit fifo_legal(logic [3:0] en);
    return en == 4'h1 || en == 4'h2 || en == 4'h4 || en == 4'h8 ||
           en == 4'h3 || en == 4'hC || en == 4'hF;
  endfunction

  initial begin
    int df, dr, de, lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1", {29'd0, fifo_we, reg_we, err}, 32'd0);
    check("R1", n_fifo + n_reg + n_err, 32'd0);

    // R6 R7 R8: sweep lanes for each FIFO address
    for (int a = 8'h40; a <= 8'h43; a++) begin
      for (int b = 0; b < 16; b++) begin
        logic [3:0]  en;
        logic [31:0] d, m;
        en = ~4'(b);
        d  = 32'h1357_9BDF ^ (a * 32'h0101_0101) ^ (b * 32'h0011_0077);
        m  = {{8{en[3]}}, {8{en[2]}}, {8{en[1]}}, {8{en[0]}}};
        addr_phase(8'(a), 24'hC3A500 ^ 24'(b));
        data_phase(d, 4'(b), 1'b1, df, dr, de, lat);
        check("R6", dr, 32'd0);
        check("R5", lat, 32'd3);
        if (fifo_legal(en)) begin
          check("R7", df, 32'd1); check("R7", de, 32'd0);
          check("R7", s_mask, en); check("R7", s_fdata, d & m);
        end else begin
          check("R8", df, 32'd0); check("R8", de, 32'd1);
        end
      end
    end

    // R9 R10 R2: register addresses with upper junk
    for (int k = 0; k < 6; k++) begin
      logic [7:0] a;
      a = (k < 3) ? 8'(k * 8'h1D) : 8'(8'h44 + k * 8'h2B);
      for (int b = 0; b < 16; b++) begin
        logic [3:0]  en;
        logic [31:0] d;
        en = ~4'(b);
        d  = 32'hA1B2_C3D4 + k * 32'h0102_0304 + b * 32'h1110_0F0E;
        addr_phase(a, 24'hFFFFFF ^ 24'(k * 977));
        data_phase(d, 4'(b), 1'b1, df, dr, de, lat);
        check("R6", df, 32'd0);
        if ($countones(en) == 1) begin
          check("R9", dr, 32'd1); check("R9", de, 32'd0);
          check("R2", s_addr, a);
          check("R9", s_rdata, (d >> (8 * $clog2(en))) & 32'hFF);
        end else begin
          check("R10", dr, 32'd0); check("R10", de, 32'd1);
        end
      end
    end

    // R3: reuse latched address without an address phase
    addr_phase(8'h12, 24'h0);
    data_phase(32'h0000_0055, 4'hE, 1'b1, df, dr, de, lat);
    data_phase(32'h0000_0066, 4'hE, 1'b1, df, dr, de, lat);
    check("R3", dr, 32'd1); check("R3", s_addr, 32'h12); check("R3", s_rdata, 32'h66);
    addr_phase(8'h42, 24'h0);
    data_phase(32'h0000_7777, 4'hC, 1'b1, df, dr, de, lat);
    data_phase(32'hDEAD_BEEF, 4'h0, 1'b1, df, dr, de, lat);
    check("R3", df, 32'd1); check("R3", s_fdata, 32'hDEAD_BEEF);

    // R4: write strobe with chip select idle commits nothing
    data_phase(32'h1234_5678, 4'h0, 1'b0, df, dr, de, lat);
    check("R4", df + dr + de, 32'd0);
    check("R4", s_fdata, 32'hDEAD_BEEF);

    done = 1;
  end

  initial begin
    int wd;
    wd = 0;
    while (!done && wd < 150000) begin @(posedge clk); wd++; end
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=done", wd);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule